// File: doc/BRIEF.md
# Supply Setpoint Supervisor

This block holds three programmable supply setpoint codes, PS1, PS2 and PS3. It also supervises shutdown and reset for the supply path that the codes drive. A host writes each 8-bit code over a small valid/ready write port. Every code counts 100 mV units in plain binary. A configuration pin can make the PS2 output repeat the PS1 code, so that one supply can serve every zone.

The block enters shutdown when any held code has one of its two top bits set, which counts as an over-voltage and also raises a program fault. It also enters shutdown when any supply reports that it is above its reference-high level, or when the remote shutdown input is asserted. Shutdown and fault are sticky. While shutdown is active, the write port applies back-pressure and all three output codes read zero. Shutdown and fault clear only on a system reset.

A system reset has four sources: the power-on sequence, a rising edge on the local reset button, a rising edge on the remote reset button, and any change of the stress-mode input. The system reset clears all setpoints, the shutdown and the fault. The analog converters and regulators are outside this block.

Top module: `supply_supervisor`

## Requirements
- R1: A write transfers when `wr_valid` and `wr_ready` are both 1 on a rising clock edge. `wr_sel` 0, 1 and 2 load PS1, PS2 and PS3, and the new code shows on the matching output from the next cycle. `wr_sel` 3 is accepted and discarded, and no code changes.
- R2: While `share_ps1` is 1 and shutdown is inactive, `ps2_code` shows the PS1 setpoint. The PS2 setpoint is kept and shows again when `share_ps1` returns to 0.
- R3: An accepted write to PS1, PS2 or PS3 whose bit 7 or bit 6 is 1 sets `shutdown` and `prog_fault` two clock edges after acceptance. A code of 0x3F or less causes neither.
- R4: Any bit of `ovr_ref_hi` at 1, or `remote_sd` at 1, passes two synchronizing flops and then sets `shutdown`. It leaves `prog_fault` at 0.
- R5: Once set, `shutdown` and `prog_fault` stay set until `sys_reset`, even after the cause goes away. While `shutdown` is 1, `wr_ready` is 0 and all three output codes read 0.
- R6: The rising edge of `local_rst_btn` or `remote_rst_btn` produces a `sys_reset` pulse of exactly RST_PULSE cycles. Each button passes two synchronizing flops first. A held button and a released button trigger nothing more.
- R7: Any change of `stress_mode`, 0 to 1 or 1 to 0, after synchronization produces the same RST_PULSE-cycle `sys_reset` pulse.
- R8: `sys_reset` is 1 while `rst_n` is 0. After `rst_n` is released it stays 1 for exactly POR_CYCLES clock cycles.
- R9: `sys_reset` clears all setpoints, `shutdown` and `prog_fault`. `wr_ready` is 0 while `sys_reset` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous chip reset; starts the power-on sequence |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write port can accept (no shutdown, no reset) |
| wr_sel | input | 2 | Target: 0 PS1, 1 PS2, 2 PS3, 3 discard |
| wr_data | input | 8 | Setpoint code in 100 mV units |
| share_ps1 | input | 1 | PS2 output follows PS1 |
| ovr_ref_hi | input | 3 | Per-supply over-reference-high flags |
| remote_sd | input | 1 | Remote shutdown request (level) |
| local_rst_btn | input | 1 | Local reset button |
| remote_rst_btn | input | 1 | Remote reset button |
| stress_mode | input | 1 | Stress / non-stress status |
| ps1_code | output | 8 | PS1 setpoint code |
| ps2_code | output | 8 | PS2 setpoint code (or PS1 when shared) |
| ps3_code | output | 8 | PS3 setpoint code |
| shutdown | output | 1 | Sticky shutdown |
| prog_fault | output | 1 | Sticky program fault (over-voltage) |
| sys_reset | output | 1 | System reset pulse |

## Verification
The assertions take it that `rst_n` is held low for at least one clock edge, and that POR_CYCLES is at least RST_PULSE, so that every `sys_reset` pulse after start-up is at least RST_PULSE cycles long. They also take it that `wr_valid` is driven only with a defined `wr_sel`. The bench drives every input at the falling clock edge and holds each button and each shutdown input for several cycles, well beyond the synchronizer depth. It drops `wr_valid` while `wr_ready` is low, so no blocked write is left waiting to complete after a reset.

// File: rtl/supsv_pkg.sv
package supsv_pkg;
  localparam int unsigned NUM_SUP = 3;
  localparam int unsigned SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SUP_PS1  = 2'd0,
    SUP_PS2  = 2'd1,
    SUP_PS3  = 2'd2,
    SUP_NONE = 2'd3
  } sup_sel_e;

  // index of each bit inside the synchronized input bundle
  localparam int unsigned SB_REF0   = 0;
  localparam int unsigned SB_RSD    = 3;
  localparam int unsigned SB_LBTN   = 4;
  localparam int unsigned SB_RBTN   = 5;
  localparam int unsigned SB_STRESS = 6;
  localparam int unsigned SB_W      = 7;
endpackage

// File: rtl/supsv_sync.sv
module supsv_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/supsv_reset_gen.sv
module supsv_reset_gen #(
  parameter int unsigned POR_CYCLES = 256,
  parameter int unsigned RST_PULSE  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lbtn_s,
  input  logic rbtn_s,
  input  logic stress_s,
  output logic sys_reset
);
  localparam int unsigned PW = $clog2(POR_CYCLES) + 1;
  localparam int unsigned CW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] por_cnt;
  logic          por_done;
  logic [CW-1:0] pulse_cnt;
  logic          lbtn_q, rbtn_q, stress_q;
  logic          trigger;

  // power-on settling counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt  <= '0;
      por_done <= 1'b0;
    end else if (!por_done) begin
      if (por_cnt == PW'(POR_CYCLES - 1)) por_done <= 1'b1;
      else                                por_cnt  <= por_cnt + 1'b1;
    end
  end

  // previous-value registers for edge and change detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbtn_q   <= 1'b0;
      rbtn_q   <= 1'b0;
      stress_q <= 1'b0;
    end else begin
      lbtn_q   <= lbtn_s;
      rbtn_q   <= rbtn_s;
      stress_q <= stress_s;
    end
  end

  assign trigger = por_done &
                   ((lbtn_s & ~lbtn_q) | (rbtn_s & ~rbtn_q) | (stress_s ^ stress_q));

  // retriggerable pulse timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulse_cnt <= '0;
    else if (trigger)          pulse_cnt <= CW'(RST_PULSE);
    else if (pulse_cnt != '0)  pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign sys_reset = ~por_done | (pulse_cnt != '0);
endmodule

// File: rtl/supsv_setpoints.sv
module supsv_setpoints
  import supsv_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OV_BITS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_SUP-1:0][DATA_W-1:0]  codes,
  output logic                            ov
);
  for (genvar i = 0; i < NUM_SUP; i++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    codes[i] <= '0;
      else if (clr)                                  codes[i] <= '0;
      else if (wr_en && (wr_idx == SEL_W'(i)))       codes[i] <= wr_data;
    end
  end

  // over-voltage: any of the top OV_BITS of any held code
  always_comb begin
    ov = 1'b0;
    for (int i = 0; i < NUM_SUP; i++) begin
      ov = ov | (|codes[i][DATA_W-1 -: OV_BITS]);
    end
  end
endmodule

// File: rtl/supsv_shutdown.sv
module supsv_shutdown (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ov,
  input  logic ext_sd,
  output logic shutdown,
  output logic prog_fault
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown   <= 1'b0;
      prog_fault <= 1'b0;
    end else if (clr) begin
      shutdown   <= 1'b0;
      prog_fault <= 1'b0;
    end else begin
      shutdown   <= shutdown | ov | ext_sd;
      prog_fault <= prog_fault | ov;
    end
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsv_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OV_BITS     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POR_CYCLES  = 256,
  parameter int unsigned RST_PULSE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              share_ps1,
  input  logic [NUM_SUP-1:0] ovr_ref_hi,
  input  logic              remote_sd,
  input  logic              local_rst_btn,
  input  logic              remote_rst_btn,
  input  logic              stress_mode,
  output logic [DATA_W-1:0] ps1_code,
  output logic [DATA_W-1:0] ps2_code,
  output logic [DATA_W-1:0] ps3_code,
  output logic              shutdown,
  output logic              prog_fault,
  output logic              sys_reset
);
  logic [SB_W-1:0]                 raw_in, syn_in;
  logic [NUM_SUP-1:0][DATA_W-1:0]  codes;
  logic                            ov;
  logic                            ext_sd;
  logic                            wr_en;

  assign raw_in = {stress_mode, remote_rst_btn, local_rst_btn, remote_sd, ovr_ref_hi};

  supsv_sync #(.WIDTH(SB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (syn_in)
  );

  supsv_reset_gen #(.POR_CYCLES(POR_CYCLES), .RST_PULSE(RST_PULSE)) u_rstgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .lbtn_s    (syn_in[SB_LBTN]),
    .rbtn_s    (syn_in[SB_RBTN]),
    .stress_s  (syn_in[SB_STRESS]),
    .sys_reset (sys_reset)
  );

  assign wr_ready = ~shutdown & ~sys_reset;
  assign wr_en    = wr_valid & wr_ready & (wr_sel != SUP_NONE);

  supsv_setpoints #(.DATA_W(DATA_W), .OV_BITS(OV_BITS)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sys_reset),
    .wr_en   (wr_en),
    .wr_idx  (wr_sel),
    .wr_data (wr_data),
    .codes   (codes),
    .ov      (ov)
  );

  assign ext_sd = (|syn_in[SB_REF0 +: NUM_SUP]) | syn_in[SB_RSD];

  supsv_shutdown u_sd (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (sys_reset),
    .ov         (ov),
    .ext_sd     (ext_sd),
    .shutdown   (shutdown),
    .prog_fault (prog_fault)
  );

  always_comb begin
    if (shutdown) begin
      ps1_code = '0;
      ps2_code = '0;
      ps3_code = '0;
    end else begin
      ps1_code = codes[SUP_PS1];
      ps2_code = share_ps1 ? codes[SUP_PS1] : codes[SUP_PS2];
      ps3_code = codes[SUP_PS3];
    end
  end
endmodule

// File: rtl/supsv_checker.sv
module supsv_checker #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OV_BITS   = 2,
  parameter int unsigned RST_PULSE = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [1:0]         wr_sel,
  input logic [OV_BITS-1:0] wr_top,
  input logic               share_ps1,
  input logic [DATA_W-1:0]  ps1_code,
  input logic [DATA_W-1:0]  ps2_code,
  input logic               shutdown,
  input logic               prog_fault,
  input logic               sys_reset
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_len <= '0;
    else if (!sys_reset)    run_len <= '0;
    else if (run_len != '1) run_len <= run_len + 1'b1;
  end

  assert_ov_shutdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_sel != 2'd3 && (|wr_top)) ##1 !sys_reset
      |=> shutdown && prog_fault);

  assert_shutdown_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown && !sys_reset |=> shutdown);

  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fault && !sys_reset |=> prog_fault);

  assert_fault_implies_sd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fault |-> shutdown);

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> !shutdown && !prog_fault);

  assert_share_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    share_ps1 |-> ps2_code == ps1_code);

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_reset) |-> run_len >= 16'(RST_PULSE));
endmodule

bind supply_supervisor supsv_checker #(
  .DATA_W(DATA_W), .OV_BITS(OV_BITS), .RST_PULSE(RST_PULSE)
) u_supsv_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_sel     (wr_sel),
  .wr_top     (wr_data[DATA_W-1 -: OV_BITS]),
  .share_ps1  (share_ps1),
  .ps1_code   (ps1_code),
  .ps2_code   (ps2_code),
  .shutdown   (shutdown),
  .prog_fault (prog_fault),
  .sys_reset  (sys_reset)
);

// File: tb/test_supply_supervisor.sv
`timescale 1ns/1ps
module test_supply_supervisor;
  localparam int POR_CYCLES = 256;
  localparam int RST_PULSE  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       share_ps1 = 1'b0;
  logic [2:0] ovr_ref_hi = 3'b000;
  logic       remote_sd = 1'b0;
  logic       local_rst_btn = 1'b0;
  logic       remote_rst_btn = 1'b0;
  logic       stress_mode = 1'b0;
  logic [7:0] ps1_code, ps2_code, ps3_code;
  logic       shutdown, prog_fault, sys_reset;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  supply_supervisor #(.POR_CYCLES(POR_CYCLES), .RST_PULSE(RST_PULSE)) i_supply_supervisor (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .share_ps1(share_ps1),
    .ovr_ref_hi(ovr_ref_hi), .remote_sd(remote_sd),
    .local_rst_btn(local_rst_btn), .remote_rst_btn(remote_rst_btn),
    .stress_mode(stress_mode), .ps1_code(ps1_code), .ps2_code(ps2_code),
    .ps3_code(ps3_code), .shutdown(shutdown), .prog_fault(prog_fault),
    .sys_reset(sys_reset)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // called at a negedge just after a trigger input was driven
  task automatic measure_pulse(input string req);
    int waitc;
    int len;
    waitc = 0;
    while (!sys_reset && waitc < 8) begin @(negedge clk); waitc++; end
    chk("R9", "wr_ready during reset", int'(wr_ready), 0);
    len = 0;
    while (sys_reset && len < 200) begin len++; @(negedge clk); end
    chk(req, "reset pulse length", len, RST_PULSE);
  endtask

  task automatic t_por;
    int len;
    wait_neg(3);
    chk("R8", "sys_reset in chip reset", int'(sys_reset), 1);
    chk("R9", "wr_ready in chip reset", int'(wr_ready), 0);
    chk("R9", "codes in chip reset", int'({ps1_code, ps2_code, ps3_code}), 0);
    rst_n = 1'b1;
    len = 0;
    while (sys_reset && len < POR_CYCLES + 50) begin len++; @(negedge clk); end
    chk("R8", "power-on reset length", len, POR_CYCLES);
  endtask

  task automatic t_write;
    do_write(2'd0, 8'h12);
    chk("R1", "ps1 after write", int'(ps1_code), 'h12);
    do_write(2'd1, 8'h34);
    chk("R1", "ps2 after write", int'(ps2_code), 'h34);
    do_write(2'd2, 8'h3F);
    chk("R1", "ps3 after write", int'(ps3_code), 'h3F);
    do_write(2'd3, 8'h55);
    chk("R1", "sel 3 discarded", int'({ps1_code, ps2_code, ps3_code}), 'h12343F);
    wait_neg(2);
    chk("R3", "0x3F no shutdown", int'({shutdown, prog_fault}), 0);
  endtask

  task automatic t_share;
    share_ps1 = 1'b1;
    #1;
    chk("R2", "ps2 follows ps1", int'(ps2_code), 'h12);
    @(negedge clk);
    share_ps1 = 1'b0;
    #1;
    chk("R2", "ps2 own value kept", int'(ps2_code), 'h34);
  endtask

  task automatic t_overvoltage;
    do_write(2'd2, 8'h40);
    chk("R3", "no shutdown one edge after", int'(shutdown), 0);
    @(negedge clk);
    chk("R3", "shutdown from bit 6", int'(shutdown), 1);
    chk("R3", "fault from bit 6", int'(prog_fault), 1);
    chk("R5", "codes zero in shutdown", int'({ps1_code, ps2_code, ps3_code}), 0);
    chk("R5", "wr_ready low in shutdown", int'(wr_ready), 0);
    wait_neg(10);
    chk("R5", "shutdown sticky", int'({shutdown, prog_fault}), 3);
    local_rst_btn = 1'b1;
    measure_pulse("R6");
    local_rst_btn = 1'b0;
    chk("R9", "shutdown cleared", int'({shutdown, prog_fault}), 0);
    chk("R9", "setpoints cleared", int'({ps1_code, ps2_code, ps3_code}), 0);
    chk("R9", "wr_ready back", int'(wr_ready), 1);
    do_write(2'd0, 8'h80);
    @(negedge clk);
    chk("R3", "bit 7 shutdown and fault", int'({shutdown, prog_fault}), 3);
    remote_rst_btn = 1'b1;
    measure_pulse("R6");
    remote_rst_btn = 1'b0;
    chk("R9", "cleared by remote button", int'({shutdown, prog_fault}), 0);
  endtask

  task automatic t_external;
    do_write(2'd0, 8'h21);
    @(negedge clk);
    ovr_ref_hi = 3'b100;
    wait_neg(4);
    ovr_ref_hi = 3'b000;
    wait_neg(4);
    chk("R4", "ref-high shutdown", int'(shutdown), 1);
    chk("R4", "ref-high no fault", int'(prog_fault), 0);
    chk("R5", "ps1 zero in shutdown", int'(ps1_code), 0);
    stress_mode = 1'b1;
    measure_pulse("R7");
    chk("R9", "cleared by stress rise", int'(shutdown), 0);
    chk("R9", "ps1 cleared", int'(ps1_code), 0);
    remote_sd = 1'b1;
    wait_neg(4);
    remote_sd = 1'b0;
    wait_neg(4);
    chk("R4", "remote shutdown", int'({shutdown, prog_fault}), 2);
    stress_mode = 1'b0;
    measure_pulse("R7");
    chk("R9", "cleared by stress fall", int'(shutdown), 0);
  endtask

  task automatic t_hold;
    int highs;
    local_rst_btn = 1'b1;
    measure_pulse("R6");
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sys_reset) highs++;
    end
    chk("R6", "held button no retrigger", highs, 0);
    local_rst_btn = 1'b0;
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sys_reset) highs++;
    end
    chk("R6", "release no trigger", highs, 0);
  endtask

  initial begin
    t_por();
    t_write();
    t_share();
    t_overvoltage();
    t_external();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule